// File: doc/BRIEF.md
# Redundant Address Configuration Loader

This block fills a set of volatile shadow registers from a small non-volatile byte store. The store is addressed with 4 bits and holds 16 bytes; only locations 0 to 6 carry data. Loading starts when the slave's reset has ended and a start pulse arrives. The loader reads each used location in turn, keeping each address on the memory port for a fixed number of clock cycles. The two locations that hold the slave address are then compared. If they differ, for example because a supply dip tore an earlier address write, the block reports a zero address and raises an abnormal-operation flag. The address and setting fields are then offered to the rest of the slave.

After loading, the block also accepts byte writes. Each write first updates the shadow register. The shadow contents are then written back to the store with a long, parameterised busy time. An address write always goes to location 0 first and then to location 1. The busy output stays high until both bytes are stored. A request that cannot be served is refused with a one-cycle error pulse. The serial wiring of a real store is not modelled: the memory port is a plain byte port with a combinational read path, and the loader itself counts the access times.

Top module: `cfg_shadow_loader`

## Requirements
- R1: While reset is high and in the first cycle after it, load_done_o, wr_busy_o, wr_err_o, abnormal_o, mem_rd_o and mem_we_o are 0, and every field output is 0.
- R2: A start_i pulse after reset reads locations 0,1,2,3,4,5,6 in that order. Each is held on mem_addr_o with mem_rd_o high for RD_CYC cycles. load_done_o rises RD_CYC*7+1 cycles after the edge that samples start_i, and addr_o reads 0 until then.
- R3: Once loaded, eid1_o = loc2[3:0], iocfg_o = loc3[4:0], id_o = loc4[4:0], eid2_o = loc5[4:0], ctrl_o = loc6[4:0].
- R4: With ext_mode_i = 1 at the compare cycle, the copies match when loc0[5:0] = loc1[5:0], and addr_o = loc0[5:0]. Bits 7:6 are ignored.
- R5: With ext_mode_i = 0 at the compare cycle, only bits 4:0 are compared, and addr_o = {0, loc0[4:0]}.
- R6: If the compared bits differ, addr_o = 0 and abnormal_o = 1. abnormal_o is never 1 before load_done_o.
- R7: A write with wr_field_i = 0 or 1 (the address field) stores wr_data_i into location 0 for WR_CYC cycles and then into location 1 for WR_CYC cycles. wr_busy_o is high for exactly 2*WR_CYC cycles. From the cycle after acceptance, addr_o shows the new value and abnormal_o is 0.
- R8: A write with wr_field_i = 2..6 stores wr_data_i into that location. wr_busy_o is high for WR_CYC cycles, and the matching field output shows the new value.
- R9: A request made before load_done_o, while wr_busy_o is high, or with wr_field_i = 7 is refused. wr_err_o is high for exactly the one cycle after the request, and no memory location changes.
- R10: start_i has no effect once loading has begun. No further read happens, and load_done_o stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin loading the shadow registers |
| ext_mode_i | input | 1 | 1: six-bit address compare, 0: five-bit |
| wr_req_i | input | 1 | Write request, one cycle |
| wr_field_i | input | 3 | 0/1 address pair, 2..6 single location, 7 invalid |
| wr_data_i | input | 8 | Byte to write |
| mem_addr_o | output | 4 | Memory location |
| mem_rd_o | output | 1 | Read in progress |
| mem_we_o | output | 1 | Write in progress |
| mem_wdata_o | output | 8 | Byte written, taken from the shadow register |
| mem_rdata_i | input | 8 | Byte read from the addressed location |
| load_done_o | output | 1 | Shadow registers valid |
| wr_busy_o | output | 1 | Write in progress |
| wr_err_o | output | 1 | Refused request, one-cycle pulse |
| abnormal_o | output | 1 | Address copies disagreed |
| addr_o | output | 6 | Effective slave address |
| eid1_o | output | 4 | Setting from location 2 |
| iocfg_o | output | 5 | Setting from location 3 |
| id_o | output | 5 | Setting from location 4 |
| eid2_o | output | 5 | Setting from location 5 |
| ctrl_o | output | 5 | Setting from location 6 |

## Verification
The bench builds the loader with RD_CYC = 3 and WR_CYC = 20. These stand in for the millisecond access times, so a full load takes 22 cycles and an address-pair write takes 40. With these values the exact load-done cycle and the full busy window can be counted directly. A refused request can also be placed in the middle of a write. The short times let many load cycles run, covering agreeing, torn and upper-bit-only address differences in both compare modes.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

    localparam int MEM_DEPTH = 16;
    localparam int MEM_AW    = $clog2(MEM_DEPTH);
    localparam int NUM_LOC   = 7;
    localparam int LOC_W     = $clog2(NUM_LOC);
    localparam int ADDR_W    = 6;

    localparam logic [LOC_W-1:0] LAST_LOC    = LOC_W'(NUM_LOC - 1);
    localparam logic [2:0]       FIELD_BAD   = 3'd7;
    localparam logic [MEM_AW-1:0] COPY_A_LOC = '0;
    localparam logic [MEM_AW-1:0] COPY_B_LOC = MEM_AW'(1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_CHECK,
        ST_READY,
        ST_WRITE
    } seq_state_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [3:0]        eid1;
        logic [4:0]        iocfg;
        logic [4:0]        id;
        logic [4:0]        eid2;
        logic [4:0]        ctrl;
    } cfg_view_t;

    function automatic logic copies_agree(input logic [7:0] a,
                                          input logic [7:0] b,
                                          input logic       ext);
        if (ext) return a[5:0] == b[5:0];
        return a[4:0] == b[4:0];
    endfunction

    function automatic logic [ADDR_W-1:0] visible_addr(input logic [7:0] a,
                                                       input logic       ext);
        if (ext) return a[5:0];
        return {1'b0, a[4:0]};
    endfunction

    function automatic logic field_is_pair(input logic [2:0] f);
        return f <= 3'd1;
    endfunction

endpackage

// File: rtl/cfgl_tick_timer.sv
module cfgl_tick_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             last_o
);

    logic [CNT_W-1:0] cnt_q;

    assign last_o = en_i && (cnt_q == limit_i - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (en_i) begin
            cnt_q <= last_o ? '0 : cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/cfgl_sequencer.sv
module cfgl_sequencer
    import cfgl_pkg::*;
#(
    parameter int RD_CYC = 4,
    parameter int WR_CYC = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              wr_req_i,
    input  logic [2:0]        wr_field_i,
    output logic [MEM_AW-1:0] mem_addr_o,
    output logic              mem_rd_o,
    output logic              mem_we_o,
    output logic              capture_o,
    output logic [LOC_W-1:0]  cap_idx_o,
    output logic              check_o,
    output logic              accept_o,
    output logic              busy_o,
    output logic              err_o
);

    localparam int LONGEST = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
    localparam int CNT_W   = $clog2(LONGEST + 1);

    seq_state_t        state_q;
    logic [LOC_W-1:0]  idx_q;
    logic [MEM_AW-1:0] wloc_q;
    logic              pair_q;
    logic              err_q;
    logic              tmr_en;
    logic              tmr_last;
    logic [CNT_W-1:0]  tmr_lim;
    logic              req_ok;

    cfgl_tick_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .en_i    (tmr_en),
        .limit_i (tmr_lim),
        .last_o  (tmr_last)
    );

    always_comb begin
        mem_rd_o   = (state_q == ST_LOAD);
        mem_we_o   = (state_q == ST_WRITE);
        tmr_en     = mem_rd_o || mem_we_o;
        tmr_lim    = mem_rd_o ? CNT_W'(RD_CYC) : CNT_W'(WR_CYC);
        if (mem_rd_o)      mem_addr_o = MEM_AW'(idx_q);
        else if (mem_we_o) mem_addr_o = wloc_q;
        else               mem_addr_o = '0;
        req_ok     = (state_q == ST_READY) && (wr_field_i != FIELD_BAD);
        capture_o  = mem_rd_o && tmr_last;
        cap_idx_o  = idx_q;
        check_o    = (state_q == ST_CHECK);
        accept_o   = wr_req_i && req_ok;
        busy_o     = mem_we_o;
        err_o      = err_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            wloc_q  <= '0;
            pair_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            err_q <= wr_req_i && !req_ok;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_LOAD;
                        idx_q   <= '0;
                    end
                end
                ST_LOAD: begin
                    if (tmr_last) begin
                        if (idx_q == LAST_LOC) state_q <= ST_CHECK;
                        else                   idx_q   <= idx_q + LOC_W'(1);
                    end
                end
                ST_CHECK: begin
                    state_q <= ST_READY;
                end
                ST_READY: begin
                    if (accept_o) begin
                        state_q <= ST_WRITE;
                        pair_q  <= field_is_pair(wr_field_i);
                        wloc_q  <= field_is_pair(wr_field_i) ? COPY_A_LOC
                                                             : MEM_AW'(wr_field_i);
                    end
                end
                ST_WRITE: begin
                    if (tmr_last) begin
                        if (pair_q && wloc_q == COPY_A_LOC) wloc_q  <= COPY_B_LOC;
                        else                                state_q <= ST_READY;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cfgl_shadow_bank.sv
module cfgl_shadow_bank
    import cfgl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture_i,
    input  logic [LOC_W-1:0]  cap_idx_i,
    input  logic [7:0]        cap_data_i,
    input  logic              check_i,
    input  logic              ext_i,
    input  logic              accept_i,
    input  logic [2:0]        wr_field_i,
    input  logic [7:0]        wr_data_i,
    input  logic [MEM_AW-1:0] rd_sel_i,
    output logic [7:0]        rd_data_o,
    output logic              done_o,
    output logic              mismatch_o,
    output cfg_view_t         view_o
);

    logic [7:0] sh_q [NUM_LOC];
    logic       mode_q;
    logic       mism_q;
    logic       done_q;

    for (genvar g = 0; g < NUM_LOC; g++) begin : g_shadow
        logic hit_cap;
        logic hit_wr;
        assign hit_cap = capture_i && (cap_idx_i == LOC_W'(g));
        if (g < 2) begin : g_pair
            assign hit_wr = accept_i && field_is_pair(wr_field_i);
        end else begin : g_single
            assign hit_wr = accept_i && (wr_field_i == 3'(g));
        end
        always_ff @(posedge clk) begin
            if (rst)          sh_q[g] <= '0;
            else if (hit_cap) sh_q[g] <= cap_data_i;
            else if (hit_wr)  sh_q[g] <= wr_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= 1'b0;
            mism_q <= 1'b0;
            done_q <= 1'b0;
        end else if (check_i) begin
            mode_q <= ext_i;
            mism_q <= !copies_agree(sh_q[0], sh_q[1], ext_i);
            done_q <= 1'b1;
        end else if (accept_i && field_is_pair(wr_field_i)) begin
            mism_q <= 1'b0;
        end
    end

    always_comb begin
        rd_data_o = '0;
        if (rd_sel_i < MEM_AW'(NUM_LOC)) rd_data_o = sh_q[rd_sel_i[LOC_W-1:0]];
    end

    always_comb begin
        view_o = '0;
        if (done_q) begin
            view_o.addr  = mism_q ? '0 : visible_addr(sh_q[0], mode_q);
            view_o.eid1  = sh_q[2][3:0];
            view_o.iocfg = sh_q[3][4:0];
            view_o.id    = sh_q[4][4:0];
            view_o.eid2  = sh_q[5][4:0];
            view_o.ctrl  = sh_q[6][4:0];
        end
    end

    assign done_o     = done_q;
    assign mismatch_o = done_q && mism_q;

endmodule

// File: rtl/cfg_shadow_loader.sv
module cfg_shadow_loader
    import cfgl_pkg::*;
#(
    parameter int RD_CYC = 4,
    parameter int WR_CYC = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              ext_mode_i,
    input  logic              wr_req_i,
    input  logic [2:0]        wr_field_i,
    input  logic [7:0]        wr_data_i,
    output logic [MEM_AW-1:0] mem_addr_o,
    output logic              mem_rd_o,
    output logic              mem_we_o,
    output logic [7:0]        mem_wdata_o,
    input  logic [7:0]        mem_rdata_i,
    output logic              load_done_o,
    output logic              wr_busy_o,
    output logic              wr_err_o,
    output logic              abnormal_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [3:0]        eid1_o,
    output logic [4:0]        iocfg_o,
    output logic [4:0]        id_o,
    output logic [4:0]        eid2_o,
    output logic [4:0]        ctrl_o
);

    logic             capture;
    logic [LOC_W-1:0] cap_idx;
    logic             check;
    logic             accept;
    cfg_view_t        view;

    cfgl_sequencer #(.RD_CYC(RD_CYC), .WR_CYC(WR_CYC)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .wr_req_i   (wr_req_i),
        .wr_field_i (wr_field_i),
        .mem_addr_o (mem_addr_o),
        .mem_rd_o   (mem_rd_o),
        .mem_we_o   (mem_we_o),
        .capture_o  (capture),
        .cap_idx_o  (cap_idx),
        .check_o    (check),
        .accept_o   (accept),
        .busy_o     (wr_busy_o),
        .err_o      (wr_err_o)
    );

    cfgl_shadow_bank u_bank (
        .clk        (clk),
        .rst        (rst),
        .capture_i  (capture),
        .cap_idx_i  (cap_idx),
        .cap_data_i (mem_rdata_i),
        .check_i    (check),
        .ext_i      (ext_mode_i),
        .accept_i   (accept),
        .wr_field_i (wr_field_i),
        .wr_data_i  (wr_data_i),
        .rd_sel_i   (mem_addr_o),
        .rd_data_o  (mem_wdata_o),
        .done_o     (load_done_o),
        .mismatch_o (abnormal_o),
        .view_o     (view)
    );

    assign addr_o  = view.addr;
    assign eid1_o  = view.eid1;
    assign iocfg_o = view.iocfg;
    assign id_o    = view.id;
    assign eid2_o  = view.eid2;
    assign ctrl_o  = view.ctrl;

endmodule

// File: rtl/cfg_shadow_loader_chk.sv
module cfg_shadow_loader_chk (
    input logic       clk,
    input logic       rst,
    input logic       load_done_o,
    input logic       wr_busy_o,
    input logic       wr_err_o,
    input logic       abnormal_o,
    input logic [5:0] addr_o,
    input logic       wr_req_i,
    input logic       mem_rd_o,
    input logic       mem_we_o,
    input logic [3:0] mem_addr_o
);

    AST_ADDR_ZERO_UNLOADED: assert property (@(posedge clk) disable iff (rst)
        !load_done_o |-> addr_o == '0); // R2

    AST_RD_ASCENDING: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_o && $past(mem_rd_o)) |->
        (mem_addr_o == $past(mem_addr_o) || mem_addr_o == $past(mem_addr_o) + 4'd1)); // R2

    AST_ABN_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
        abnormal_o |-> load_done_o); // R6

    AST_ABN_ZERO_ADDR: assert property (@(posedge clk) disable iff (rst)
        abnormal_o |-> addr_o == '0); // R6

    AST_NO_RD_WR_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_o && mem_we_o)); // R7

    AST_WE_WITHIN_BUSY: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |-> (wr_busy_o && load_done_o)); // R8

    AST_ERR_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
        wr_err_o |-> $past(wr_req_i)); // R9

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        load_done_o |=> (load_done_o && !mem_rd_o)); // R10

endmodule

bind cfg_shadow_loader cfg_shadow_loader_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .load_done_o (load_done_o),
    .wr_busy_o   (wr_busy_o),
    .wr_err_o    (wr_err_o),
    .abnormal_o  (abnormal_o),
    .addr_o      (addr_o),
    .wr_req_i    (wr_req_i),
    .mem_rd_o    (mem_rd_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o)
);

// File: tb/cfg_shadow_loader_bench.sv
`timescale 1ns/1ps
module cfg_shadow_loader_bench;

    localparam int RD = 3;
    localparam int WR = 20;
    localparam int NVEC = 7;
    localparam int WATCHDOG = 20000;

    // {ext nibble, abnormal nibble, loc0, loc1, expected addr}
    localparam logic [31:0] VEC [NVEC] = '{
        32'h10252525,  // R4 agree, extended
        32'h11250500,  // R6 differ in bit 5, extended
        32'h00250505,  // R5 bit 5 ignored, normal
        32'h01131200,  // R6 differ in bit 0, normal
        32'h00DF1F1F,  // R5 upper bits ignored
        32'h10DF1F1F,  // R4 bits 7:6 ignored
        32'h113F3E00   // R6 extended differ
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       ext = 1'b0;
    logic       wr_req = 1'b0;
    logic [2:0] wr_field = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] mem_addr;
    logic       mem_rd, mem_we;
    logic [7:0] mem_wdata, mem_rdata;
    logic       load_done, wr_busy, wr_err, abnormal;
    logic [5:0] addr;
    logic [3:0] eid1;
    logic [4:0] iocfg, id, eid2, ctrl;

    logic [7:0] bmem [16];
    int rd_cnt [16];
    int checks = 0;
    int fails = 0;
    int cycles = 0;
    logic order_bad = 1'b0;
    logic [3:0] prev_rd = '0;

    always #2.5 clk = ~clk;

    cfg_shadow_loader #(.RD_CYC(RD), .WR_CYC(WR)) u_cfg_shadow_loader (
        .clk(clk), .rst(rst), .start_i(start), .ext_mode_i(ext),
        .wr_req_i(wr_req), .wr_field_i(wr_field), .wr_data_i(wr_data),
        .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_we_o(mem_we),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
        .load_done_o(load_done), .wr_busy_o(wr_busy), .wr_err_o(wr_err),
        .abnormal_o(abnormal), .addr_o(addr), .eid1_o(eid1),
        .iocfg_o(iocfg), .id_o(id), .eid2_o(eid2), .ctrl_o(ctrl)
    );

    assign mem_rdata = bmem[mem_addr];

    always @(posedge clk) if (mem_we) bmem[mem_addr] <= mem_wdata;

    always @(negedge clk) begin
        if (mem_rd) begin
            rd_cnt[mem_addr] = rd_cnt[mem_addr] + 1;
            if (mem_addr < prev_rd) order_bad = 1'b1;
            prev_rd = mem_addr;
        end
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 16; i++) rd_cnt[i] = 0;
        order_bad = 1'b0;
        prev_rd = '0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_load(output int n);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        n = 0;
        for (int k = 0; k < 200; k++) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (load_done) break;
            check(addr == 6'd0, "R2 addr before done", int'(addr), 0);
        end
    endtask

    task automatic write_req(input logic [2:0] f, input logic [7:0] d);
        wr_field = f;
        wr_data = d;
        wr_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_req = 1'b0;
    endtask

    task automatic wait_busy(output int n);
        n = 0;
        for (int k = 0; k < 500; k++) begin
            if (!wr_busy) break;
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        cycles = 0;
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                fails++;
                $display("FAIL watchdog: actual %0d expected below %0d", cycles, WATCHDOG);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        int n;
        for (int i = 0; i < 16; i++) bmem[i] = 8'(8'h80 + i);
        bmem[2] = 8'hA9; bmem[3] = 8'hF6; bmem[4] = 8'h2B;
        bmem[5] = 8'h11; bmem[6] = 8'hE7;

        for (int v = 0; v < NVEC; v++) begin
            bmem[0] = VEC[v][23:16];
            bmem[1] = VEC[v][15:8];
            ext = VEC[v][28];
            do_reset();
            if (v == 0) begin
                // R1 reset state
                check(!load_done && !wr_busy && !wr_err && !abnormal && !mem_rd && !mem_we,
                      "R1 status after reset",
                      int'({load_done, wr_busy, wr_err, abnormal, mem_rd, mem_we}), 0);
                check({addr, eid1, iocfg, id, eid2, ctrl} == '0, "R1 fields after reset",
                      int'({addr, eid1, iocfg, id, eid2, ctrl}), 0);
            end
            run_load(n);
            check(n == 7 * RD + 1, "R2 load cycles", n, 7 * RD + 1);
            check(addr == VEC[v][5:0], "R4/R5/R6 address", int'(addr), int'(VEC[v][5:0]));
            check(abnormal == VEC[v][24], "R6 abnormal flag", int'(abnormal), int'(VEC[v][24]));
            if (v == 0) begin
                for (int i = 0; i < 16; i++)
                    check(rd_cnt[i] == (i < 7 ? RD : 0), "R2 read count", rd_cnt[i], i < 7 ? RD : 0);
                check(!order_bad, "R2 read order", int'(order_bad), 0);
                check(eid1 == 4'h9 && iocfg == 5'h16 && id == 5'h0B && eid2 == 5'h11 && ctrl == 5'h07,
                      "R3 setting fields", int'({eid1, iocfg, id, eid2, ctrl}),
                      int'({4'h9, 5'h16, 5'h0B, 5'h11, 5'h07}));
            end
        end

        // R10: start after loading is ignored
        for (int i = 0; i < 16; i++) rd_cnt[i] = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        check(load_done && rd_cnt[0] == 0 && rd_cnt[6] == 0, "R10 start ignored",
              rd_cnt[0] + rd_cnt[6], 0);

        // R9: invalid field refused
        write_req(3'd7, 8'h55);
        check(wr_err && !wr_busy, "R9 invalid field error", int'({wr_err, wr_busy}), 2);
        @(negedge clk);
        check(!wr_err, "R9 error single cycle", int'(wr_err), 0);

        // R7: address pair write, clears abnormal (last vector left it set)
        write_req(3'd0, 8'h2A);
        check(!wr_err && addr == 6'h2A && !abnormal, "R7 new address visible",
              int'(addr), 8'h2A);
        wait_busy(n);
        check(n == 2 * WR, "R7 busy length", n, 2 * WR);
        check(bmem[0] == 8'h2A && bmem[1] == 8'h2A, "R7 both copies stored",
              int'({bmem[0], bmem[1]}), 16'h2A2A);

        // R8 single write, with a refused request in the middle (R9)
        write_req(3'd4, 8'h0D);
        write_req(3'd5, 8'h1E);
        check(wr_err, "R9 refused while busy", int'(wr_err), 1);
        wait_busy(n);
        check(n == WR - 1, "R8 busy length", n + 1, WR);
        check(bmem[4] == 8'h0D && id == 5'h0D, "R8 location 4 stored",
              int'(bmem[4]), 8'h0D);
        check(bmem[5] == 8'h11 && eid2 == 5'h11, "R9 location 5 untouched",
              int'(bmem[5]), 8'h11);

        // R9: request before loading is refused
        do_reset();
        write_req(3'd3, 8'h01);
        check(wr_err && !wr_busy, "R9 refused before load", int'({wr_err, wr_busy}), 2);
        repeat (WR + 2) @(negedge clk);
        check(bmem[3] == 8'hF6, "R9 memory unchanged before load", int'(bmem[3]), 8'hF6);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule